// File: doc/BRIEF.md
# Partial reconfiguration completion detector

This block decides when a freshly loaded partial configuration region is complete and safe to use. It needs no status flag from the configuration engine. The region exposes an 8-bit signature that comes from lookup-table ROM contents written by the partial configuration itself. Flip-flop initial values cannot be used for this, because no global set/reset happens during a partial load. The signature reads ASCII 'O' (0x4F) before the load and ASCII 'N' (0x4E) after it. Once the new marker has been seen as stable, the block waits out a settling interval sized from the bitstream length. It then raises a sticky done flag.

A second way to detect the end of the load is optional. A monitor on the 32-bit configuration data stream watches for the desynchronise command word, 0x0000000D. The external test port has priority over the single configuration engine. While an ownership input shows that the test port holds the engine, stream results are ignored and the settling countdown is paused. Software arms the block when the old marker is present and clears it to start over.

Top module: `pr_done_detect`

## Requirements
- R1: After reset, done_o, busy_o and err_o are all low and the block is idle.
- R2: A one-cycle arm_i pulse in idle moves the block to armed (busy_o high on the following cycle). This happens only when the synchronised signature currently equals 0x4F. Otherwise arm_i is ignored and busy_o stays low.
- R3: The signature passes through a two-flop synchroniser. The value 0x4E counts as the new marker only after STABLE_N (default 4) consecutive synchronised samples. Shorter runs of 0x4E, or of any other value, leave the block armed with done_o low.
- R4: The settle interval is SETTLE = ceil(BITSTREAM_BITS/BUS_W) + MARGIN cycles. The signature is driven to 0x4E before clock edge 0 and then held. done_o is first high after SETTLE + STABLE_N + 5 rising edges, and busy_o stays high until then.
- R5: While the block is armed, a word equal to 0x0000000D with cfg_valid_i high sends it straight to settling. done_o is first high SETTLE + 3 edges after that word. Other word values, and 0x0000000D with cfg_valid_i low, have no effect.
- R6: While ext_owner_i is high, desynchronise words are ignored, the settle countdown holds, and done_o cannot rise. Holding ext_owner_i for P cycles inside the countdown delays done_o by exactly P cycles.
- R7: In the armed state, a signature that is neither 0x4F nor 0x4E for STABLE_N consecutive synchronised samples raises err_o and drops busy_o. err_o is first high STABLE_N + 3 edges after the bad value is driven. It stays high until clr_i.
- R8: done_o stays high until clr_i and rises only once per arming, even when both completion events occur. clr_i has priority over arm_i and returns the block to idle with all outputs low on the next cycle.
- R9: busy_o is high exactly while the block waits for completion (armed, marker seen, settling). It is never high together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | 8 | Signature from the reconfigurable region (asynchronous) |
| cfg_word_i | input | 32 | Configuration data word |
| cfg_valid_i | input | 1 | Qualifies cfg_word_i |
| ext_owner_i | input | 1 | External test port currently holds the configuration engine |
| arm_i | input | 1 | Start watching for completion |
| clr_i | input | 1 | Return to idle and clear all flags |
| done_o | output | 1 | Sticky completion flag |
| busy_o | output | 1 | Waiting for completion |
| err_o | output | 1 | Sticky unexpected-signature flag |

## Verification
The bench mixes random runs of the 'N' marker and random foreign values, each shorter than the stability window, into the old marker. A design that trusts a single sample of a half-written region would finish early. Exact-cycle checks of done against the computed interval catch a design that drops the rounding or the margin, or miscounts the synchroniser stages by one. Desynchronise words that are unqualified or seen while the external port owns the engine must change nothing, and ownership inside the countdown must stretch it cycle for cycle. Both completion events in one arming must give a single done rise, and a stable foreign signature must raise a sticky error.

// File: rtl/pr_done_pkg.sv
package pr_done_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SEEN_NEW,
    ST_SETTLING,
    ST_DONE
  } pr_state_e;

  typedef enum logic [1:0] {
    SIG_OLD,
    SIG_NEW,
    SIG_OTHER
  } sig_cls_e;

  localparam logic [7:0]  MARK_OLD    = 8'h4F;
  localparam logic [7:0]  MARK_NEW    = 8'h4E;
  localparam logic [31:0] DESYNC_WORD = 32'h0000_000D;

endpackage

// File: rtl/pr_sig_sync.sv
module pr_sig_sync
  import pr_done_pkg::*;
#(
  parameter int unsigned       SIG_W    = 8,
  parameter int unsigned       STABLE_N = 4,
  parameter logic [SIG_W-1:0]  OLD_MARK = 8'h4F,
  parameter logic [SIG_W-1:0]  NEW_MARK = 8'h4E
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SIG_W-1:0] sig_i,
  output logic             old_o,
  output logic             new_stable_o,
  output logic             other_stable_o
);

  localparam int unsigned RUN_W = $clog2(STABLE_N + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STABLE_N);

  logic [SIG_W-1:0] sync1_q, sync2_q;
  sig_cls_e         cls_d, cls_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= sig_i;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    if (sync2_q == OLD_MARK)      cls_d = SIG_OLD;
    else if (sync2_q == NEW_MARK) cls_d = SIG_NEW;
    else                          cls_d = SIG_OTHER;
  end

  // run length of the current class, saturating at STABLE_N
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q <= SIG_OTHER;
      run_q <= '0;
    end else if (cls_d != cls_q) begin
      cls_q <= cls_d;
      run_q <= RUN_W'(1);
    end else if (run_q != RUN_MAX) begin
      run_q <= run_q + RUN_W'(1);
    end
  end

  assign old_o          = (cls_q == SIG_OLD);
  assign new_stable_o   = (cls_q == SIG_NEW)   && (run_q == RUN_MAX);
  assign other_stable_o = (cls_q == SIG_OTHER) && (run_q == RUN_MAX);

  p_new_from_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_stable_o |-> $past(sync2_q) == NEW_MARK);

  p_stable_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({old_o, new_stable_o, other_stable_o}));

endmodule

// File: rtl/pr_desync_mon.sv
module pr_desync_mon #(
  parameter int unsigned        WORD_W = 32,
  parameter bit                 ENABLE = 1'b1,
  parameter logic [WORD_W-1:0]  DESYNC = 32'h0000_000D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  input  logic              block_i,
  output logic              hit_o
);

  if (ENABLE) begin : g_mon
    logic hit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hit_q <= 1'b0;
      else         hit_q <= valid_i && !block_i && (word_i == DESYNC);
    end
    assign hit_o = hit_q;

    p_hit_qualified_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> $past(valid_i) && !$past(block_i));
  end else begin : g_off
    assign hit_o = 1'b0;
  end

endmodule

// File: rtl/pr_settle_cnt.sv
module pr_settle_cnt #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LOAD_VAL = 132
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);

  localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(LOAD_VAL);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (load_i)                      cnt_q <= LOAD_C;
    else if (run_i && cnt_q != '0)        cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  p_cnt_pause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !run_i |=> $stable(cnt_q));

  p_cnt_no_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && $past(cnt_q) == '0 && !$past(load_i) |-> cnt_q == '0);

endmodule

// File: rtl/pr_done_detect.sv
module pr_done_detect
  import pr_done_pkg::*;
#(
  parameter int unsigned BITSTREAM_BITS = 4096,
  parameter int unsigned BUS_W          = 32,
  parameter int unsigned MARGIN         = 4,
  parameter int unsigned STABLE_N       = 4,
  parameter bit          USE_STREAM     = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  sig_i,
  input  logic [31:0] cfg_word_i,
  input  logic        cfg_valid_i,
  input  logic        ext_owner_i,
  input  logic        arm_i,
  input  logic        clr_i,
  output logic        done_o,
  output logic        busy_o,
  output logic        err_o
);

  localparam int unsigned SETTLE = (BITSTREAM_BITS + BUS_W - 1) / BUS_W + MARGIN;
  localparam int unsigned CNT_W  = $clog2(SETTLE + 1);

  logic      old_s, new_s, other_s, desync_hit, cnt_zero, cnt_load, cnt_run;
  pr_state_e state_q, state_d;
  logic      err_q, err_d;

  pr_sig_sync #(
    .SIG_W(8), .STABLE_N(STABLE_N), .OLD_MARK(MARK_OLD), .NEW_MARK(MARK_NEW)
  ) u_sync (
    .clk_i, .rst_ni, .sig_i,
    .old_o(old_s), .new_stable_o(new_s), .other_stable_o(other_s)
  );

  pr_desync_mon #(
    .WORD_W(32), .ENABLE(USE_STREAM), .DESYNC(DESYNC_WORD)
  ) u_mon (
    .clk_i, .rst_ni, .word_i(cfg_word_i), .valid_i(cfg_valid_i),
    .block_i(ext_owner_i), .hit_o(desync_hit)
  );

  pr_settle_cnt #(.CNT_W(CNT_W), .LOAD_VAL(SETTLE)) u_cnt (
    .clk_i, .rst_ni, .load_i(cnt_load), .run_i(cnt_run), .zero_o(cnt_zero)
  );

  assign cnt_run = (state_q == ST_SETTLING) && !ext_owner_i;

  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    cnt_load = 1'b0;
    if (clr_i) begin
      state_d = ST_IDLE;
      err_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE:     if (arm_i && old_s) state_d = ST_ARMED;
        ST_ARMED: begin
          if (desync_hit) begin
            state_d  = ST_SETTLING;
            cnt_load = 1'b1;
          end else if (new_s) begin
            state_d = ST_SEEN_NEW;
          end else if (other_s) begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
          end
        end
        ST_SEEN_NEW: begin
          state_d  = ST_SETTLING;
          cnt_load = 1'b1;
        end
        ST_SETTLING: if (!ext_owner_i && cnt_zero) state_d = ST_DONE;
        ST_DONE:     state_d = ST_DONE;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign done_o = (state_q == ST_DONE);
  assign busy_o = (state_q == ST_ARMED) || (state_q == ST_SEEN_NEW) ||
                  (state_q == ST_SETTLING);
  assign err_o  = err_q;

  p_busy_done_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clr_i |=> done_o);

  p_clr_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_o && !busy_o && !err_o);

  p_done_after_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cnt_zero) && !$past(ext_owner_i));

  p_ext_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SETTLING && ext_owner_i && !clr_i |=> state_q == ST_SETTLING);

  p_arm_needs_old_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && !old_s |=> !busy_o);

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clr_i |=> err_o);

endmodule

// File: tb/pr_done_detect_bench.sv
module pr_done_detect_bench;

  localparam int unsigned BITS   = 1000;
  localparam int unsigned W      = 32;
  localparam int unsigned MARGIN = 3;
  localparam int unsigned STAB   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sig = 8'h00;
  logic [31:0] word = '0;
  logic        valid = 1'b0, ext = 1'b0, arm = 1'b0, clr = 1'b0;
  logic        done, busy, err;

  int checks = 0, fails = 0, rises = 0;
  bit finished = 1'b0;
  logic done_prev = 1'b0;

  always #2 clk = ~clk;

  pr_done_detect #(
    .BITSTREAM_BITS(BITS), .BUS_W(W), .MARGIN(MARGIN), .STABLE_N(STAB), .USE_STREAM(1'b1)
  ) u_pr_done_detect (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig), .cfg_word_i(word), .cfg_valid_i(valid),
    .ext_owner_i(ext), .arm_i(arm), .clr_i(clr), .done_o(done), .busy_o(busy), .err_o(err)
  );

  always @(posedge clk) begin
    if (done && !done_prev) rises <= rises + 1;
    done_prev <= done;
  end

  function automatic int settle_len();
    return (BITS + W - 1) / W + MARGIN;
  endfunction
  function automatic int lat_new();
    return settle_len() + STAB + 5;
  endfunction
  function automatic int lat_desync();
    return settle_len() + 3;
  endfunction
  function automatic logic [7:0] foreign_val();
    logic [7:0] v = 8'($urandom);
    if (v == 8'h4E || v == 8'h4F) v = 8'h00;
    return v;
  endfunction
  function automatic logic [31:0] non_desync();
    logic [31:0] v = $urandom;
    if (v == 32'h0000_000D) v = 32'h0000_000E;
    return v;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_arm();
    sig = 8'h4F;
    step(6);
    arm = 1'b1;
    step(1);
    arm = 1'b0;
    check("R2 busy after arm", busy, 1);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    arm = 1'b1;
    step(1);
    clr = 1'b0;
    arm = 1'b0;
    check("R8 clear done", done, 0);
    check("R8 clear busy (clr beats arm)", busy, 0);
    check("R8 clear err", err, 0);
  endtask

  initial begin
    int r0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    step(3);
    check("R1 reset done", done, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset err", err, 0);
    rst_n = 1'b1;
    step(1);

    // R2: arm ignored without old marker
    sig = 8'h00;
    step(6);
    arm = 1'b1;
    step(1);
    arm = 1'b0;
    step(1);
    check("R2 arm ignored without 0x4F", busy, 0);

    // R3/R4: random short glitches, then stable new marker
    do_arm();
    r0 = rises;
    for (int k = 0; k < 8; k++) begin
      int len = 1 + int'($urandom % 3);
      sig = ($urandom % 2) ? 8'h4E : foreign_val();
      step(len);
      sig = 8'h4F;
      step(3);
      check("R3 short run keeps busy", busy, 1);
      check("R3 short run no done", done, 0);
      check("R3 short run no err", err, 0);
    end
    sig = 8'h4E;
    step(lat_new() - 1);
    check("R4 done not early", done, 0);
    check("R9 busy while settling", busy, 1);
    step(1);
    check("R4 done at computed edge", done, 1);
    check("R9 busy low when done", busy, 0);
    // R8: sticky under random stimulus
    for (int k = 0; k < 20; k++) begin
      sig   = 8'($urandom);
      valid = 1'($urandom);
      word  = ($urandom % 4 == 0) ? 32'h0000_000D : non_desync();
      step(1);
      check("R8 done sticky", done, 1);
    end
    valid = 1'b0;
    check("R8 single rise", rises - r0, 1);
    do_clear();

    // R5: desync path with noise
    do_arm();
    r0 = rises;
    for (int k = 0; k < 12; k++) begin
      if (k % 3 == 0) begin
        word = 32'h0000_000D;
        valid = 1'b0;
      end else begin
        word = non_desync();
        valid = 1'b1;
      end
      step(1);
    end
    valid = 1'b0;
    step(2);
    check("R5 noise words ignored busy", busy, 1);
    check("R5 noise words ignored done", done, 0);
    word = 32'h0000_000D;
    valid = 1'b1;
    step(1);
    valid = 1'b0;
    step(lat_desync() - 2);
    check("R5 done not early", done, 0);
    step(1);
    check("R5 done at computed edge", done, 1);
    // both events: new marker after desync completion
    sig = 8'h4E;
    step(lat_new() + 5);
    check("R8 one rise with both events", rises - r0, 1);
    do_clear();

    // R6: external ownership
    do_arm();
    ext = 1'b1;
    word = 32'h0000_000D;
    valid = 1'b1;
    step(1);
    valid = 1'b0;
    step(lat_desync() + 2);
    check("R6 desync ignored under ext busy", busy, 1);
    check("R6 desync ignored under ext done", done, 0);
    ext = 1'b0;
    sig = 8'h4E;
    step(STAB + 5);
    ext = 1'b1;
    step(10);
    ext = 1'b0;
    step(lat_new() + 10 - 1 - (STAB + 5) - 10);
    check("R6 done delayed by hold, not early", done, 0);
    step(1);
    check("R6 done delayed by hold", done, 1);
    do_clear();

    // R7: stable foreign signature
    do_arm();
    sig = 8'h5A;
    step(STAB + 2);
    check("R7 err not early", err, 0);
    step(1);
    check("R7 err raised", err, 1);
    check("R7 busy dropped", busy, 0);
    sig = 8'h4F;
    step(5);
    check("R7 err sticky", err, 1);
    do_clear();

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule